// File: doc/BRIEF.md
# Packet-Count Transmit Start Threshold Gate

This block tells a transmit engine when it may begin a burst out of a FIFO that holds only whole packets. It keeps a count of the complete packets in the FIFO. The count rises on each packet-write-complete pulse and falls on each packet-transmit-complete pulse. A registered start permit is raised once that count reaches a start level. The start level depends on a small control register, the link speed, the role and the number of descriptors available.

When thresholding is switched on, the link runs in its fastest mode and the register contents are legal, the start level is the programmed packet threshold. The gate also outputs a burst cap that tells the engine how many packets one burst may send at most. In every other case the gate falls back to a single-packet start rule. The start level never exceeds the packets left in the current transfer, so the final short burst still starts.

The engine takes the permit by pulsing a start input. The permit then stays low until the engine reports that the burst is done. The next start decision is made one cycle after that report.

Top module: `pkt_tx_gate`

## Requirements
- R1: The control register holds the enable at bit 29, the threshold at bits 27:24 and the burst cap at bits 23:16. All fields reset to 0. A write on `cfg_we` updates all three fields on the next clock. All other bits read as 0 whatever was written, so writing 0xFFFFFFFF reads back 0x2FFF0000.
- R2: With the enable bit at 0, the permit is raised once at least one complete packet is held.
- R3: With the enable bit at 1, `ss_mode` at 1 and a legal register, the permit is raised only once the held packet count reaches the threshold.
- R4: With `ss_mode` at 0, the one-packet rule applies whatever the register holds.
- R5: With `dev_role` at 1 and `desc_avail` below the effective threshold, the one-packet rule applies instead of the threshold.
- R6: The register is illegal when the threshold is 0, the cap is 0, the cap is above 16, or the threshold is above the cap. An illegal register makes the effective threshold 1 and the effective cap 16.
- R7: `burst_cap` equals the register cap when the enable bit is 1, `ss_mode` is 1 and the register is legal. Otherwise it is 16, and 16 is also its value after reset.
- R8: The start level is the smaller of the needed level and `xfer_left`. When `xfer_left` is 0, no permit is given.
- R9: `pkt_count` rises by 1 on a write-complete and falls by 1 on a transmit-complete. It saturates at 16 and at 0. When both pulses arrive in the same cycle, the count does not change.
- R10: The permit is registered. It reflects the condition one cycle later. It drops in the cycle after `burst_start` is sampled with the permit high, stays low through the burst, stays low in the cycle after `burst_done`, and may rise again one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| ss_mode | input | 1 | Link runs in its fastest mode |
| dev_role | input | 1 | Block acts in device role |
| desc_avail | input | 5 | Descriptors available for the coming packets |
| xfer_left | input | 8 | Packets remaining in the current transfer |
| pkt_wr_done | input | 1 | One complete packet written into the FIFO |
| pkt_tx_done | input | 1 | One packet fully sent out of the FIFO |
| burst_start | input | 1 | Engine takes the permit and starts a burst |
| burst_done | input | 1 | Engine finished the current burst |
| start_ok | output | 1 | Registered start permit |
| burst_cap | output | 5 | Effective maximum packets per burst |
| pkt_count | output | 5 | Complete packets held in the FIFO |

## Verification
The bench walks the threshold boundary: a count one short of the threshold must keep the permit low, and a design that compared with the wrong sign would start one packet early. It drives illegal register contents, a short tail transfer and scarce descriptors. A gate missing the clamp or the min-with-remaining rule would never start in these cases. It also checks the counter at 16 and 0 and under simultaneous pulses, where a wrapping or double-counting design would corrupt the count. Finally it checks the one-cycle gap after a burst ends, which a combinational permit would skip.

// File: rtl/pkt_gate_pkg.sv
package pkt_gate_pkg;

    localparam int REG_W   = 32;
    localparam int EN_BIT  = 29;
    localparam int THR_LSB = 24;
    localparam int THR_W   = 4;
    localparam int MB_LSB  = 16;
    localparam int MB_W    = 8;

    localparam logic [REG_W-1:0] RD_MASK =
        (REG_W'(1) << EN_BIT) |
        (((REG_W'(1) << THR_W) - REG_W'(1)) << THR_LSB) |
        (((REG_W'(1) << MB_W) - REG_W'(1)) << MB_LSB);

    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] thr;
        logic [MB_W-1:0]  mb;
    } cfg_t;

    typedef struct packed {
        logic busy;
        logic ok;
    } gate_st_t;

endpackage

// File: rtl/pkt_gate_cfg.sv
module pkt_gate_cfg
    import pkt_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.en  = wdata[EN_BIT];
            cfg_d.thr = wdata[THR_LSB +: THR_W];
            cfg_d.mb  = wdata[MB_LSB +: MB_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata                     = '0;
        rdata[EN_BIT]             = cfg_q.en;
        rdata[THR_LSB +: THR_W]   = cfg_q.thr;
        rdata[MB_LSB +: MB_W]     = cfg_q.mb;
    end

    assign cfg = cfg_q;

    // R1: a write reaches the read port one clock later with reserved bits cleared
    p_write_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & RD_MASK)));

endmodule

// File: rtl/pkt_gate_cnt.sv
module pkt_gate_cnt #(
    parameter int CNT_MAX = 16,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != TOP)
            cnt_d = cnt_q + CNT_W'(1);
        else if (dec && !inc && cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R9: simultaneous pulses leave the count alone
    p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));
    // R9: saturation at the top
    p_sat_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q == TOP) |=> (cnt_q == TOP));
    // R9: a lone write-complete below the top adds one
    p_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pkt_gate_level.sv
module pkt_gate_level
    import pkt_gate_pkg::*;
#(
    parameter int MAX_BURST = 16,
    parameter int CNT_W     = 5,
    parameter int XFER_W    = 8,
    parameter int DESC_W    = 5,
    localparam int CAP_W    = $clog2(MAX_BURST + 1),
    localparam int LW       = (XFER_W > DESC_W ? XFER_W : DESC_W) + MB_W + CNT_W
) (
    input  cfg_t              cfg,
    input  logic              ss_mode,
    input  logic              dev_role,
    input  logic [DESC_W-1:0] desc_avail,
    input  logic [XFER_W-1:0] xfer_left,
    input  logic [CNT_W-1:0]  cnt,
    output logic              meet,
    output logic [CAP_W-1:0]  cap
);

    logic          legal, gated, bypass;
    logic [LW-1:0] thr_eff, need, level;

    always_comb begin
        legal = (cfg.thr != '0) && (cfg.mb != '0) &&
                (LW'(cfg.mb) <= LW'(MAX_BURST)) &&
                (LW'(cfg.thr) <= LW'(cfg.mb));
        thr_eff = legal ? LW'(cfg.thr) : LW'(1);
        gated   = cfg.en && ss_mode;
        bypass  = dev_role && (LW'(desc_avail) < thr_eff);
        need    = (gated && !bypass) ? thr_eff : LW'(1);
        level   = (LW'(xfer_left) < need) ? LW'(xfer_left) : need;
        meet    = (xfer_left != '0) && (LW'(cnt) >= level);
        cap     = (gated && legal) ? CAP_W'(cfg.mb) : CAP_W'(MAX_BURST);
    end

endmodule

// File: rtl/pkt_gate_fsm.sv
module pkt_gate_fsm
    import pkt_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic meet,
    input  logic take,
    input  logic done,
    output logic ok
);

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && st_q.ok && take)
            st_d.busy = 1'b1;
        else if (st_q.busy && done)
            st_d.busy = 1'b0;
        st_d.ok = !st_q.busy && !(st_q.ok && take) && meet;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok = st_q.ok;

    // R10: permit drops right after being taken
    p_drop_on_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ok && take) |=> !st_q.ok);
    // R10: no permit in the cycle after the burst-done report
    p_gap_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && done) |=> !st_q.ok);
    // R10: permit follows the start condition of the previous cycle
    p_needs_meet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !meet |=> !st_q.ok);

endmodule

// File: rtl/pkt_tx_gate.sv
module pkt_tx_gate
    import pkt_gate_pkg::*;
#(
    parameter int CNT_MAX   = 16,
    parameter int MAX_BURST = 16,
    parameter int XFER_W    = 8,
    parameter int DESC_W    = 5,
    localparam int CNT_W    = $clog2(CNT_MAX + 1),
    localparam int CAP_W    = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              ss_mode,
    input  logic              dev_role,
    input  logic [DESC_W-1:0] desc_avail,
    input  logic [XFER_W-1:0] xfer_left,
    input  logic              pkt_wr_done,
    input  logic              pkt_tx_done,
    input  logic              burst_start,
    input  logic              burst_done,
    output logic              start_ok,
    output logic [CAP_W-1:0]  burst_cap,
    output logic [CNT_W-1:0]  pkt_count
);

    cfg_t cfg;
    logic meet;

    pkt_gate_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    pkt_gate_cnt #(.CNT_MAX(CNT_MAX)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pkt_wr_done),
        .dec   (pkt_tx_done),
        .cnt   (pkt_count)
    );

    pkt_gate_level #(
        .MAX_BURST (MAX_BURST),
        .CNT_W     (CNT_W),
        .XFER_W    (XFER_W),
        .DESC_W    (DESC_W)
    ) u_level (
        .cfg        (cfg),
        .ss_mode    (ss_mode),
        .dev_role   (dev_role),
        .desc_avail (desc_avail),
        .xfer_left  (xfer_left),
        .cnt        (pkt_count),
        .meet       (meet),
        .cap        (burst_cap)
    );

    pkt_gate_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .meet  (meet),
        .take  (burst_start),
        .done  (burst_done),
        .ok    (start_ok)
    );

endmodule

// File: tb/test_pkt_tx_gate.sv
module test_pkt_tx_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ss_mode = 1'b1;
    logic        dev_role = 1'b0;
    logic [4:0]  desc_avail = 5'd31;
    logic [7:0]  xfer_left = 8'd50;
    logic        pkt_wr_done = 1'b0;
    logic        pkt_tx_done = 1'b0;
    logic        burst_start = 1'b0;
    logic        burst_done = 1'b0;
    logic        start_ok;
    logic [4:0]  burst_cap;
    logic [4:0]  pkt_count;

    always #5 clk = ~clk;

    pkt_tx_gate i_pkt_tx_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ss_mode(ss_mode), .dev_role(dev_role),
        .desc_avail(desc_avail), .xfer_left(xfer_left),
        .pkt_wr_done(pkt_wr_done), .pkt_tx_done(pkt_tx_done),
        .burst_start(burst_start), .burst_done(burst_done),
        .start_ok(start_ok), .burst_cap(burst_cap), .pkt_count(pkt_count)
    );

    int    checks = 0;
    int    fails = 0;
    string tag = "R10";

    task automatic chk(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_thr, m_mb;
    bit m_busy, m_ok, m_en;

    function automatic bit m_legal();
        return m_thr >= 1 && m_mb >= 1 && m_mb <= 16 && m_thr <= m_mb;
    endfunction

    function automatic bit m_meet();
        int te, need, lvl;
        te = m_legal() ? m_thr : 1;
        need = 1;
        if (m_en && ss_mode && !(dev_role && int'(desc_avail) < te)) need = te;
        lvl = (int'(xfer_left) < need) ? int'(xfer_left) : need;
        return xfer_left != 0 && m_cnt >= lvl;
    endfunction

    function automatic int m_cap();
        return (m_en && ss_mode && m_legal()) ? m_mb : 16;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_thr = 0; m_mb = 0;
            m_busy = 0; m_ok = 0; m_en = 0;
        end else begin
            bit n_ok, n_busy;
            n_ok = !m_busy && !(m_ok && burst_start) && m_meet();
            n_busy = m_busy;
            if (!m_busy && m_ok && burst_start) n_busy = 1;
            else if (m_busy && burst_done) n_busy = 0;
            if (pkt_wr_done && !pkt_tx_done && m_cnt < 16) m_cnt++;
            else if (pkt_tx_done && !pkt_wr_done && m_cnt > 0) m_cnt--;
            if (cfg_we) begin
                m_en  = cfg_wdata[29];
                m_thr = int'(cfg_wdata[27:24]);
                m_mb  = int'(cfg_wdata[23:16]);
            end
            m_ok = n_ok;
            m_busy = n_busy;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, "start_ok", start_ok, m_ok);
            chk("R9", "pkt_count", pkt_count, m_cnt);
            chk("R7", "burst_cap", burst_cap, m_cap());
            chk("R1", "cfg_rdata", cfg_rdata,
                (longint'(m_en) << 29) | (longint'(m_thr) << 24) | (longint'(m_mb) << 16));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_cfg(logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pkts(int n);
        for (int i = 0; i < n; i++) begin
            pkt_wr_done = 1'b1; tick(); pkt_wr_done = 1'b0;
        end
    endtask

    task automatic sends(int n);
        for (int i = 0; i < n; i++) begin
            pkt_tx_done = 1'b1; tick(); pkt_tx_done = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        // R1: reset values
        chk("R1", "reset rdata", cfg_rdata, 0);
        chk("R10", "reset start_ok", start_ok, 0);
        chk("R9", "reset count", pkt_count, 0);
        chk("R7", "reset cap", burst_cap, 16);
        rst_n = 1'b1;
        tick();

        tag = "R1";
        wr_cfg(32'hFFFF_FFFF);
        chk("R1", "reserved bits", cfg_rdata, 32'h2FFF_0000);

        tag = "R3";
        wr_cfg(32'h2408_0000);              // enable, threshold 4, cap 8
        pkts(3); step(2);
        chk("R3", "below threshold", start_ok, 0);
        pkts(1); tick();
        chk("R3", "at threshold", start_ok, 1);

        tag = "R10";
        burst_start = 1'b1; tick(); burst_start = 1'b0;
        chk("R10", "drop after start", start_ok, 0);
        step(3);
        chk("R10", "low while busy", start_ok, 0);
        burst_done = 1'b1; tick(); burst_done = 1'b0;
        chk("R10", "gap after done", start_ok, 0);
        tick();
        chk("R10", "rise after gap", start_ok, 1);

        tag = "R9";
        sends(4);
        chk("R9", "drained", pkt_count, 0);
        pkts(20);
        chk("R9", "saturate high", pkt_count, 16);
        pkt_wr_done = 1'b1; pkt_tx_done = 1'b1; tick();
        pkt_wr_done = 1'b0; pkt_tx_done = 1'b0;
        chk("R9", "simultaneous", pkt_count, 16);
        sends(17);
        chk("R9", "saturate low", pkt_count, 0);

        tag = "R2";
        wr_cfg(32'h0408_0000);
        pkts(1); step(2);
        chk("R2", "disabled one packet", start_ok, 1);

        tag = "R4";
        wr_cfg(32'h2408_0000);
        step(2);
        chk("R3", "enabled one packet low", start_ok, 0);
        ss_mode = 1'b0; step(2);
        chk("R4", "slow link one packet", start_ok, 1);
        chk("R7", "slow link cap", burst_cap, 16);
        ss_mode = 1'b1;

        tag = "R5";
        dev_role = 1'b1; desc_avail = 5'd2; step(2);
        chk("R5", "few descriptors", start_ok, 1);
        desc_avail = 5'd6; step(2);
        chk("R5", "enough descriptors", start_ok, 0);
        dev_role = 1'b0; desc_avail = 5'd31;

        tag = "R8";
        pkts(1);
        xfer_left = 8'd2; step(2);
        chk("R8", "short tail", start_ok, 1);
        xfer_left = 8'd0; step(2);
        chk("R8", "empty transfer", start_ok, 0);
        xfer_left = 8'd50; step(2);

        tag = "R6";
        wr_cfg(32'h2008_0000);              // threshold 0
        chk("R6", "thr0 cap", burst_cap, 16);
        step(1);
        chk("R6", "thr0 permit", start_ok, 1);
        wr_cfg(32'h2903_0000);              // threshold 9 above cap 3
        chk("R6", "thr>cap cap", burst_cap, 16);
        step(1);
        chk("R6", "thr>cap permit", start_ok, 1);
        wr_cfg(32'h2400_0000);              // cap 0
        chk("R6", "cap0", burst_cap, 16);
        wr_cfg(32'h2414_0000);              // cap 20
        chk("R6", "cap20", burst_cap, 16);

        tag = "R7";
        wr_cfg(32'h2408_0000);
        chk("R7", "legal cap", burst_cap, 8);
        step(1);
        chk("R3", "two of four", start_ok, 0);

        // mixed traffic against the model
        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            pkt_wr_done = ($urandom_range(0, 9) < 3);
            pkt_tx_done = ($urandom_range(0, 9) < 2);
            burst_start = ($urandom_range(0, 3) == 0);
            burst_done  = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 49) == 0) ss_mode = ~ss_mode;
            if ($urandom_range(0, 29) == 0) dev_role = ~dev_role;
            if ($urandom_range(0, 9) == 0) desc_avail = 5'($urandom_range(0, 20));
            if ($urandom_range(0, 19) == 0) xfer_left = 8'($urandom_range(0, 20));
            cfg_we = ($urandom_range(0, 39) == 0);
            cfg_wdata = {$urandom_range(0, 255) > 60 ? 3'b001 : 3'b000,
                         1'b0, 4'($urandom_range(0, 15)),
                         8'($urandom_range(0, 20)), 16'($urandom)};
            cfg_wdata[31:30] = 2'($urandom);
            tick();
        end
        pkt_wr_done = 0; pkt_tx_done = 0; burst_start = 0;
        burst_done = 0; cfg_we = 0;
        step(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule